// File: doc/BRIEF.md
# Configurable Serial Audio Frame Transmitter

The block turns one left/right sample pair and two 16-bit codec-control words into a continuous serial stream. Each frame is 64 bit-clock periods long. The block generates the bit clock itself at half the system clock rate, together with a word-select line and a single data line. Configuration inputs set the start bit of each of the four slots inside the frame: left sample, right sample, control word one and control word two. Other inputs set the active level of word-select, whether word-select is a level or a one-bit pulse, and the bit-clock edge on which data changes.

An upstream formatter supplies the samples. A one-cycle request strobe at the start of every frame asks it for the next pair. A register interface supplies the control words through write strobes. Frames run without pause whether or not transmission is enabled. While transmission is disabled, the sample slots carry an idle word and control-word writes are dropped.

Top module: `audio_frame_tx`

## Requirements
- R1: While `rst` is high (synchronous, active high), `sck_o`, `sd_o` and `req_o` are low one clock after each reset edge.
- R2: `sck_o` toggles on every clock. Each bit lasts two clocks, low half first, and a frame is 64 bits. `req_o` is high for exactly the first clock of every frame except the first one after reset.
- R3: A sample slot carries its word MSB first, starting at its position field. Slots wrap from bit 63 to bit 0. Bits that no enabled slot covers are sent as 0.
- R4: When its enable is 1, a control word occupies 16 bits from its position. Where slots overlap, the priority is control word one, then control word two, then left, then right. A disabled control word is not inserted.
- R5: With `ws_pulse`=0, word-select equals `ws_pol` for bits b where (b-left_pos) mod 64 < (right_pos-left_pos) mod 64, and equals the inverse elsewhere. Equal positions give no active bits.
- R6: With `ws_pulse`=1, word-select equals `ws_pol` during bit 0 only and equals its inverse otherwise.
- R7: With `edge_rise`=0, data and word-select for bit k are presented during both halves of bit k. With `edge_rise`=1, they appear from the rising half of bit k through the low half of bit k+1.
- R8: The following are sampled in the last clock of a frame and hold for the whole next frame: positions, enables, `tx_en`, `left_in`, `right_in` and `idle_in`. Changes made inside a frame do not alter that frame.
- R9: With `tx_en`=0, both sample slots carry `idle_in`, and bit clock and `req_o` keep running.
- R10: A control-word write (`cc1_wr` or `cc2_wr` with `cc_data`) made while `tx_en` is 1 goes out from the next frame that starts after the write. A write made while `tx_en` is 0 is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst | input | 1 | synchronous reset, active high |
| tx_en | input | 1 | transmission enable |
| ws_pol | input | 1 | active level of word-select |
| ws_pulse | input | 1 | 1: one-bit pulse at bit 0, 0: channel level |
| edge_rise | input | 1 | 1: data changes on rising bit-clock edge, 0: falling |
| left_pos | input | 6 | start bit of left slot |
| right_pos | input | 6 | start bit of right slot |
| cc1_pos | input | 6 | start bit of control word one |
| cc2_pos | input | 6 | start bit of control word two |
| cc1_en | input | 1 | insert control word one |
| cc2_en | input | 1 | insert control word two |
| left_in | input | 16 | left sample from formatter |
| right_in | input | 16 | right sample from formatter |
| idle_in | input | 16 | idle sample used while disabled |
| cc1_wr | input | 1 | write strobe for control word one |
| cc2_wr | input | 1 | write strobe for control word two |
| cc_data | input | 16 | control word write data |
| req_o | output | 1 | next-sample request, first clock of a frame |
| sck_o | output | 1 | bit clock |
| ws_o | output | 1 | word select |
| sd_o | output | 1 | serial data |

## Verification
The bench locks onto `req_o` and samples every output at the falling system-clock edge in the middle of each clock. Sample k of a frame therefore belongs to bit k/2, half k mod 2. With `edge_rise`=1, a low-half sample is compared against the previous bit, and the low-half sample of bit 0 is skipped because it belongs to the previous frame. Configuration, samples and control writes are driven before the last clock of a frame, and the expected vectors come only from the frame that follows. One directed frame changes `left_in` halfway through and expects the old word in that frame and the new word in the next.

// File: rtl/audio_frame_tx.sv
module audio_frame_tx #(
  parameter int FRAME = 64,
  parameter int SW = 16,
  parameter int CW = 16,
  localparam int PW = $clog2(FRAME)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tx_en,
  input  logic          ws_pol,
  input  logic          ws_pulse,
  input  logic          edge_rise,
  input  logic [PW-1:0] left_pos,
  input  logic [PW-1:0] right_pos,
  input  logic [PW-1:0] cc1_pos,
  input  logic [PW-1:0] cc2_pos,
  input  logic          cc1_en,
  input  logic          cc2_en,
  input  logic [SW-1:0] left_in,
  input  logic [SW-1:0] right_in,
  input  logic [SW-1:0] idle_in,
  input  logic          cc1_wr,
  input  logic          cc2_wr,
  input  logic [CW-1:0] cc_data,
  output logic          req_o,
  output logic          sck_o,
  output logic          ws_o,
  output logic          sd_o
);

  logic [PW-1:0] cnt;
  logic          ph;
  logic [PW-1:0] f_lp, f_rp, f_c1p, f_c2p;
  logic          f_c1e, f_c2e;
  logic [SW-1:0] f_l, f_r;
  logic [CW-1:0] p_c1, p_c2, a_c1, a_c2;
  logic          hold_sd, hold_ws, req_q;
  logic          bitv, wsv;

  wire last = (cnt == PW'(FRAME - 1)) && ph;
  wire w1 = cc1_wr && tx_en;
  wire w2 = cc2_wr && tx_en;

  wire [PW-1:0] o1 = cnt - f_c1p;
  wire [PW-1:0] o2 = cnt - f_c2p;
  wire [PW-1:0] ol = cnt - f_lp;
  wire [PW-1:0] orr = cnt - f_rp;
  wire [PW-1:0] span = f_rp - f_lp;

  wire [CW-1:0] sh1 = a_c1 << o1;
  wire [CW-1:0] sh2 = a_c2 << o2;
  wire [SW-1:0] shl = f_l << ol;
  wire [SW-1:0] shr = f_r << orr;

  always_comb begin
    bitv = 1'b0;
    if (f_c1e && int'(o1) < CW)      bitv = sh1[CW-1];
    else if (f_c2e && int'(o2) < CW) bitv = sh2[CW-1];
    else if (int'(ol) < SW)          bitv = shl[SW-1];
    else if (int'(orr) < SW)         bitv = shr[SW-1];
  end

  wire act = ws_pulse ? (cnt == '0) : (ol < span);
  assign wsv = ~(act ^ ws_pol);

  assign sck_o = ph;
  assign req_o = req_q;
  assign sd_o  = (edge_rise && !ph) ? hold_sd : bitv;
  assign ws_o  = (edge_rise && !ph) ? hold_ws : wsv;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0; ph <= 1'b0; req_q <= 1'b0;
      hold_sd <= 1'b0; hold_ws <= 1'b0;
      f_lp <= '0; f_rp <= '0; f_c1p <= '0; f_c2p <= '0;
      f_c1e <= 1'b0; f_c2e <= 1'b0;
      f_l <= '0; f_r <= '0;
      p_c1 <= '0; p_c2 <= '0; a_c1 <= '0; a_c2 <= '0;
    end else begin
      ph    <= ~ph;
      req_q <= last;
      if (ph) begin
        cnt     <= cnt + 1'b1;
        hold_sd <= bitv;
        hold_ws <= wsv;
      end
      if (w1) p_c1 <= cc_data;
      if (w2) p_c2 <= cc_data;
      if (last) begin
        f_lp  <= left_pos;  f_rp  <= right_pos;
        f_c1p <= cc1_pos;   f_c2p <= cc2_pos;
        f_c1e <= cc1_en;    f_c2e <= cc2_en;
        f_l   <= tx_en ? left_in  : idle_in;
        f_r   <= tx_en ? right_in : idle_in;
        a_c1  <= w1 ? cc_data : p_c1;
        a_c2  <= w2 ? cc_data : p_c2;
      end
    end
  end

endmodule

// File: rtl/audio_frame_tx_chk.sv
module audio_frame_tx_chk (
  input logic clk,
  input logic rst,
  input logic edge_rise,
  input logic req_o,
  input logic sck_o,
  input logic sd_o
);

  // R1
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!sck_o && !sd_o && !req_o));

  // R2
  a_r2_sck_toggle: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (sck_o != $past(sck_o)));

  // R2
  a_r2_req_single: assert property (@(posedge clk) disable iff (rst)
    req_o |=> !req_o);

  // R2
  a_r2_req_low_half: assert property (@(posedge clk) disable iff (rst)
    req_o |-> !sck_o);

  // R7
  a_r7_fall_launch: assert property (@(posedge clk) disable iff (rst)
    (sck_o && !edge_rise && !$past(edge_rise)) |-> $stable(sd_o));

  // R7
  a_r7_rise_launch: assert property (@(posedge clk) disable iff (rst)
    (!sck_o && edge_rise && $past(edge_rise)) |-> $stable(sd_o));

endmodule

bind audio_frame_tx audio_frame_tx_chk chk (
  .clk(clk), .rst(rst), .edge_rise(edge_rise),
  .req_o(req_o), .sck_o(sck_o), .sd_o(sd_o)
);

// File: tb/audio_frame_tx_test.sv
`timescale 1ns/1ps
module audio_frame_tx_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_en = 1'b0, ws_pol = 1'b0, ws_pulse = 1'b0, edge_rise = 1'b0;
  logic [5:0] left_pos = '0, right_pos = '0, cc1_pos = '0, cc2_pos = '0;
  logic cc1_en = 1'b0, cc2_en = 1'b0;
  logic [15:0] left_in = '0, right_in = '0, idle_in = '0, cc_data = '0;
  logic cc1_wr = 1'b0, cc2_wr = 1'b0;
  logic req_o, sck_o, ws_o, sd_o;

  logic [15:0] m_c1 = '0, m_c2 = '0;
  int total = 0, bad = 0;
  bit done = 0;

  audio_frame_tx uut (.*);

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic e_sd(int b);
    int o;
    logic [15:0] w;
    o = (b - cc1_pos + 64) % 64;
    if (cc1_en && o < 16) return m_c1[15 - o];
    o = (b - cc2_pos + 64) % 64;
    if (cc2_en && o < 16) return m_c2[15 - o];
    o = (b - left_pos + 64) % 64;
    w = tx_en ? left_in : idle_in;
    if (o < 16) return w[15 - o];
    o = (b - right_pos + 64) % 64;
    w = tx_en ? right_in : idle_in;
    if (o < 16) return w[15 - o];
    return 1'b0;
  endfunction

  function automatic logic e_ws(int b);
    bit act;
    if (ws_pulse) act = (b == 0);
    else act = ((b - left_pos + 64) % 64) < ((right_pos - left_pos + 64) % 64);
    return act ? ws_pol : !ws_pol;
  endfunction

  task automatic cc_write(input bit which, input logic [15:0] d);
    @(negedge clk);
    cc_data = d;
    if (which) cc2_wr = 1'b1; else cc1_wr = 1'b1;
    if (tx_en) begin
      if (which) m_c2 = d; else m_c1 = d;
    end
    @(negedge clk);
    cc1_wr = 1'b0; cc2_wr = 1'b0;
  endtask

  // waits for the next frame start and checks that whole frame
  task automatic run_frame(input string tag, input bit late_change, input logic [15:0] late_l);
    logic [63:0] ex_sd, ex_ws, hi_sd, hi_ws;
    int lo_bad, ck_bad, rq_bad;
    string wtag;
    @(negedge clk);
    while (!req_o) @(negedge clk);
    for (int b = 0; b < 64; b++) begin
      ex_sd[b] = e_sd(b);
      ex_ws[b] = e_ws(b);
    end
    wtag = ws_pulse ? "R6" : "R5";
    lo_bad = 0; ck_bad = 0; rq_bad = 0;
    for (int k = 0; k < 128; k++) begin
      int b;
      b = k / 2;
      if (k > 0) @(negedge clk);
      if (late_change && k == 64) left_in = late_l;
      if (sck_o != k[0]) ck_bad++;
      if (req_o != (k == 0)) rq_bad++;
      if (k[0]) begin
        hi_sd[b] = sd_o;
        hi_ws[b] = ws_o;
      end else if (!edge_rise) begin
        if (sd_o != ex_sd[b] || ws_o != ex_ws[b]) lo_bad++;
      end else if (b > 0) begin
        if (sd_o != ex_sd[b-1] || ws_o != ex_ws[b-1]) lo_bad++;
      end
    end
    check(hi_sd == ex_sd, tag, hi_sd, ex_sd);
    check(hi_ws == ex_ws, wtag, hi_ws, ex_ws);
    check(lo_bad == 0, "R7 low-half", 64'(lo_bad), 64'd0);
    check(ck_bad == 0, "R2 sck", 64'(ck_bad), 64'd0);
    check(rq_bad == 0, tx_en ? "R2 req" : "R9 req", 64'(rq_bad), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(!sck_o && !sd_o && !req_o, "R1 reset", {61'd0, sck_o, sd_o, req_o}, 64'd0);
    rst = 1'b0;

    // basic stereo layout with control words, level word-select
    tx_en = 1; left_pos = 0; right_pos = 32; cc1_pos = 16; cc2_pos = 48;
    cc1_en = 1; cc2_en = 1; ws_pol = 1; ws_pulse = 0; edge_rise = 1;
    left_in = 16'hA5C3; right_in = 16'h3C96;
    cc_write(0, 16'h1234);
    cc_write(1, 16'hF00D);
    run_frame("R4 control slots", 0, '0);
    run_frame("R10 write next frame", 0, '0);

    // wraparound and uncovered bits low
    cc1_en = 0; cc2_en = 0; left_pos = 56; right_pos = 20; edge_rise = 0;
    left_in = 16'hFFFF; right_in = 16'h8001;
    run_frame("R3 wrap", 0, '0);
    run_frame("R3 wrap", 0, '0);

    // overlap priority: cc1 over cc2 over left over right
    cc1_en = 1; cc2_en = 1; cc1_pos = 4; cc2_pos = 0; left_pos = 8; right_pos = 12;
    cc_write(0, 16'h0FF0);
    run_frame("R4 priority", 0, '0);
    run_frame("R4 priority", 0, '0);

    // equal positions give an empty level window, pulse mode
    cc1_en = 0; cc2_en = 0; left_pos = 10; right_pos = 10; ws_pol = 0;
    run_frame("R5 empty window", 0, '0);
    ws_pulse = 1; ws_pol = 1;
    run_frame("R6 pulse", 0, '0);
    run_frame("R6 pulse", 0, '0);

    // disabled: idle word, writes dropped, frames continue
    ws_pulse = 0; left_pos = 0; right_pos = 32; cc1_pos = 16; cc1_en = 1;
    tx_en = 0; idle_in = 16'h8000;
    cc_write(0, 16'hDEAD);
    run_frame("R9 idle", 0, '0);
    run_frame("R10 dropped write", 0, '0);
    tx_en = 1;
    run_frame("R10 old word kept", 0, '0);
    run_frame("R10 old word kept", 0, '0);

    // mid-frame sample change applies only to the next frame
    left_in = 16'h1111;
    run_frame("R8 boundary", 0, '0);
    run_frame("R8 old sample", 1, 16'h7E7E);
    run_frame("R8 new sample", 0, '0);

    for (int i = 0; i < 40; i++) begin
      tx_en = $urandom_range(0, 3) != 0;
      ws_pol = 1'($urandom); ws_pulse = 1'($urandom); edge_rise = 1'($urandom);
      left_pos = 6'($urandom); right_pos = 6'($urandom);
      cc1_pos = 6'($urandom); cc2_pos = 6'($urandom);
      cc1_en = 1'($urandom); cc2_en = 1'($urandom);
      left_in = 16'($urandom); right_in = 16'($urandom); idle_in = 16'($urandom);
      if ($urandom_range(0, 1) == 1) cc_write(0, 16'($urandom));
      if ($urandom_range(0, 1) == 1) cc_write(1, 16'($urandom));
      run_frame("R3 random", 0, '0);
      run_frame("R8 random", 0, '0);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule